// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers every interrupt cause of a UART into a single interrupt line. It also produces a 4-bit identity code that software reads to learn which cause is being served. The causes are line errors and breaks, received data, receive timeouts, transmit room and modem line changes. Each cause is held pending in its own flop. The pending flag is set by the cause and cleared by the register access that services it. The flag is held whether or not its enable bit is set. The enable bits only decide whether a pending cause reaches the interrupt line and the identity code.

The transmit side has two behaviours. In the normal behaviour, the transmit interrupt fires when the transmit storage goes empty. In the programmable threshold behaviour, it fires when the transmit FIFO is at or below a selectable level. In that behaviour the transmit status bit reports FIFO full instead of empty. The transmit DMA request follows the same at-or-below condition. The block sits beside the register file and the FIFOs. It takes their level signals and access strobes, and it returns combinational status toward the read path.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, and after reset is released, the enable bits and the threshold select are zero and no cause is pending. With all enables clear, irq is 0 and iir_code is 0001.
- R2: A pulse on ovr_err, par_err, frm_err or brk_det sets the line status cause at the next edge. An lsr_rd without a new error clears it. When the cause is enabled (cfg_ier[2]) it reports 0110 ahead of every other cause.
- R3: The received-data cause is a registered copy of a condition. With fifo_en=0 the condition is rx_level non-zero. With fifo_en=1 it is rx_trig, and rx_level is ignored. It reports 0100, and it ranks above the timeout cause.
- R4: A pulse on rx_timeout sets the timeout cause. An rbr_rd without a new timeout clears it. It reports 1100 when no line status or received-data cause is shown.
- R5: The single enable bit cfg_ier[0] gates both the received-data cause and the timeout cause. With it clear, neither cause affects irq or iir_code.
- R6: Programmable mode is off when cfg_ier[4]=0 or fifo_en=0. In that case the transmit cause (enable cfg_ier[1]) is set on the edge where tx_level becomes 0. It is cleared by thr_wr, or by iir_rd while iir_code shows 0010. While tx_level stays 0 it is not raised again.
- R7: Programmable mode is on when cfg_ier[4]=1 and fifo_en=1. The threshold is chosen by cfg_tet: 00 is 0 entries, 01 is 2, 10 is TX_DEPTH/4 and 11 is TX_DEPTH/2. The transmit cause is set when tx_level first reaches a value at or below the threshold. It is cleared when tx_level is above the threshold, or by iir_rd while 0010 is shown.
- R8: lsr_thre equals (tx_level == TX_DEPTH) when programmable mode is on, and (tx_level == 0) otherwise.
- R9: dma_tx_req equals (tx_level at or below the threshold) when programmable mode is on, and (tx_level == 0) otherwise.
- R10: A pulse on ddsr, teri or ddcd sets the modem cause, which reports 0000. A pulse on dcts does the same only when auto_flow=0. An msr_rd without a new change clears the cause.
- R11: irq is 1 exactly when some cause is both pending and enabled. The enable bits are cfg_ier[2] for line status, [0] for received data and timeout, [1] for transmit and [3] for modem. iir_code names the highest such cause, in the order line status, received data, timeout, transmit, modem. It shows 0001 when none is active. Configuration writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| auto_flow | input | 1 | Automatic flow control enabled |
| cfg_wr | input | 1 | Load cfg_ier and cfg_tet |
| cfg_ier | input | 5 | Enable bits: [0] rx/timeout, [1] transmit, [2] line, [3] modem, [4] programmable mode |
| cfg_tet | input | 2 | Transmit threshold select |
| ovr_err | input | 1 | Overrun event pulse |
| par_err | input | 1 | Parity error event pulse |
| frm_err | input | 1 | Framing error event pulse |
| brk_det | input | 1 | Break detected pulse |
| rx_level | input | RLW | Receive FIFO fill level |
| rx_trig | input | 1 | Receive FIFO at or above trigger |
| rx_timeout | input | 1 | Character timeout pulse |
| tx_level | input | TLW | Transmit FIFO fill level |
| dcts | input | 1 | CTS change pulse |
| ddsr | input | 1 | DSR change pulse |
| teri | input | 1 | Ring indicator trailing edge pulse |
| ddcd | input | 1 | DCD change pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| iir_rd | input | 1 | Identity register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt output |
| iir_code | output | 4 | Identity of the highest active cause |
| lsr_thre | output | 1 | Transmit status bit |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its defaults, RX_DEPTH = TX_DEPTH = 16. With these values the four thresholds are 0, 2, 4 and 8, all distinct. The full level of 16 is also apart from the half level, so a wrong threshold choice or a wrong full decode gives a visible mismatch. Directed sequences walk each threshold across its boundary, one level above and at the threshold. A long random phase then mixes mode changes, reads and events against the reference model.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the UART interrupt controller.
// Assumes: source indices double as priority, 0 being the highest.
package uart_irq_pkg;
    localparam int NSRC   = 5;
    localparam int S_LS   = 0;
    localparam int S_RDA  = 1;
    localparam int S_TO   = 2;
    localparam int S_THRE = 3;
    localparam int S_MS   = 4;

    localparam int IE_RX   = 0;
    localparam int IE_THRE = 1;
    localparam int IE_LS   = 2;
    localparam int IE_MS   = 3;
    localparam int IE_PROG = 4;
    localparam int IE_W    = 5;

    typedef enum logic [3:0] {
        ID_MS   = 4'b0000,
        ID_NONE = 4'b0001,
        ID_THRE = 4'b0010,
        ID_RDA  = 4'b0100,
        ID_LS   = 4'b0110,
        ID_TO   = 4'b1100
    } iir_id_e;

    typedef enum logic [1:0] {
        TET_EMPTY = 2'd0,
        TET_TWO   = 2'd1,
        TET_QTR   = 2'd2,
        TET_HALF  = 2'd3
    } tet_e;

    // Maps a source index to the identity code it reports.
    function automatic iir_id_e src_code(input int idx);
        case (idx)
            S_LS:    return ID_LS;
            S_RDA:   return ID_RDA;
            S_TO:    return ID_TO;
            S_THRE:  return ID_THRE;
            default: return ID_MS;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_srcs.sv
`timescale 1ns/1ps
// Pending flags for line status, received data, timeout and modem causes.
// Assumes: event inputs are single-cycle pulses; a new event wins over
// the clearing access in the same cycle.
module uart_irq_srcs #(
    parameter int RLW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fifo_en,
    input  logic           auto_flow,
    input  logic           ovr_err,
    input  logic           par_err,
    input  logic           frm_err,
    input  logic           brk_det,
    input  logic [RLW-1:0] rx_level,
    input  logic           rx_trig,
    input  logic           rx_timeout,
    input  logic           dcts,
    input  logic           ddsr,
    input  logic           teri,
    input  logic           ddcd,
    input  logic           lsr_rd,
    input  logic           rbr_rd,
    input  logic           msr_rd,
    output logic           ls_p,
    output logic           rda_p,
    output logic           to_p,
    output logic           ms_p
);
    logic line_evt;
    logic ms_evt;
    logic rda_cond;

    // Any line fault raises the line status cause.
    assign line_evt = ovr_err | par_err | frm_err | brk_det;
    // CTS changes are hidden while hardware flow control owns CTS.
    assign ms_evt   = (dcts & ~auto_flow) | ddsr | teri | ddcd;
    // Data present: trigger state in FIFO mode, any character otherwise.
    assign rda_cond = fifo_en ? rx_trig : (|rx_level);

    // Set/clear the four pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_p  <= 1'b0;
            rda_p <= 1'b0;
            to_p  <= 1'b0;
            ms_p  <= 1'b0;
        end else begin
            ls_p  <= line_evt | (ls_p & ~lsr_rd);
            rda_p <= rda_cond;
            to_p  <= rx_timeout | (to_p & ~rbr_rd);
            ms_p  <= ms_evt | (ms_p & ~msr_rd);
        end
    end
endmodule

// File: rtl/uart_irq_thre.sv
`timescale 1ns/1ps
// Transmit-room cause, transmit status bit and transmit DMA request.
// Assumes: TX_DEPTH >= 4 so the quarter level is non-zero; tx_level never
// exceeds TX_DEPTH.
module uart_irq_thre
    import uart_irq_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int TLW      = $clog2(TX_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_on,
    input  logic [1:0]     tet,
    input  logic [TLW-1:0] tx_level,
    input  logic           thr_wr,
    input  logic           iir_rd,
    input  logic           thre_shown,
    output logic           thre_p,
    output logic           thre_rise,
    output logic           lsr_thre,
    output logic           dma_tx_req
);
    localparam logic [TLW-1:0] LV_FULL = TLW'(TX_DEPTH);
    localparam logic [TLW-1:0] LV_TWO  = TLW'(2);
    localparam logic [TLW-1:0] LV_QTR  = TLW'(TX_DEPTH / 4);
    localparam logic [TLW-1:0] LV_HALF = TLW'(TX_DEPTH / 2);

    logic [TLW-1:0] thr_lvl;
    logic           empty;
    logic           cond;
    logic           cond_q;
    logic           clr;

    // Decode the threshold select into a fill level.
    always_comb begin
        case (tet)
            TET_EMPTY: thr_lvl = '0;
            TET_TWO:   thr_lvl = LV_TWO;
            TET_QTR:   thr_lvl = LV_QTR;
            default:   thr_lvl = LV_HALF;
        endcase
    end

    assign empty      = (tx_level == '0);
    assign cond       = prog_on ? (tx_level <= thr_lvl) : empty;
    assign thre_rise  = cond & ~cond_q;
    assign clr        = (prog_on & ~cond) | (thr_wr & ~prog_on) | (iir_rd & thre_shown);
    assign lsr_thre   = prog_on ? (tx_level == LV_FULL) : empty;
    assign dma_tx_req = cond;

    // Edge-latched pending flag; a new rise wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            thre_p <= 1'b0;
        end else begin
            cond_q <= cond;
            thre_p <= thre_rise | (thre_p & ~clr);
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
// Masks pending causes with their enables, ORs them into the interrupt and
// encodes the highest-priority survivor. Purely combinational.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    output logic            irq,
    output iir_id_e         code
);
    logic [NSRC-1:0] live;

    assign live = pend & en;
    assign irq  = |live;

    // Scan from lowest to highest priority so the highest overrides.
    always_comb begin
        code = ID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) code = src_code(i);
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
// UART interrupt controller top: holds enable bits and threshold select,
// combines the cause latches and the priority encoder.
// Assumes: register strobes last one cycle; configuration loads on cfg_wr.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter  int RX_DEPTH = 16,
    parameter  int TX_DEPTH = 16,
    localparam int RLW      = $clog2(RX_DEPTH + 1),
    localparam int TLW      = $clog2(TX_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fifo_en,
    input  logic           auto_flow,
    input  logic           cfg_wr,
    input  logic [4:0]     cfg_ier,
    input  logic [1:0]     cfg_tet,
    input  logic           ovr_err,
    input  logic           par_err,
    input  logic           frm_err,
    input  logic           brk_det,
    input  logic [RLW-1:0] rx_level,
    input  logic           rx_trig,
    input  logic           rx_timeout,
    input  logic [TLW-1:0] tx_level,
    input  logic           dcts,
    input  logic           ddsr,
    input  logic           teri,
    input  logic           ddcd,
    input  logic           lsr_rd,
    input  logic           rbr_rd,
    input  logic           iir_rd,
    input  logic           msr_rd,
    input  logic           thr_wr,
    output logic           irq,
    output logic [3:0]     iir_code,
    output logic           lsr_thre,
    output logic           dma_tx_req
);
    logic [IE_W-1:0] ier_q;
    logic [1:0]      tet_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] en_vec;
    logic            prog_on;
    logic            thre_rise;
    logic            thre_shown;
    iir_id_e         code_e;

    // Configuration register: enables and threshold select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
            tet_q <= '0;
        end else if (cfg_wr) begin
            ier_q <= cfg_ier;
            tet_q <= cfg_tet;
        end
    end

    // Spread the enable bits over the source vector; rx bit covers two.
    always_comb begin
        en_vec         = '0;
        en_vec[S_LS]   = ier_q[IE_LS];
        en_vec[S_RDA]  = ier_q[IE_RX];
        en_vec[S_TO]   = ier_q[IE_RX];
        en_vec[S_THRE] = ier_q[IE_THRE];
        en_vec[S_MS]   = ier_q[IE_MS];
    end

    assign prog_on    = ier_q[IE_PROG] & fifo_en;
    assign thre_shown = (code_e == ID_THRE);
    assign iir_code   = code_e;

    uart_irq_srcs #(.RLW(RLW)) u_srcs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .auto_flow  (auto_flow),
        .ovr_err    (ovr_err),
        .par_err    (par_err),
        .frm_err    (frm_err),
        .brk_det    (brk_det),
        .rx_level   (rx_level),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .dcts       (dcts),
        .ddsr       (ddsr),
        .teri       (teri),
        .ddcd       (ddcd),
        .lsr_rd     (lsr_rd),
        .rbr_rd     (rbr_rd),
        .msr_rd     (msr_rd),
        .ls_p       (pend[S_LS]),
        .rda_p      (pend[S_RDA]),
        .to_p       (pend[S_TO]),
        .ms_p       (pend[S_MS])
    );

    uart_irq_thre #(.TX_DEPTH(TX_DEPTH), .TLW(TLW)) u_thre (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_on    (prog_on),
        .tet        (tet_q),
        .tx_level   (tx_level),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .thre_shown (thre_shown),
        .thre_p     (pend[S_THRE]),
        .thre_rise  (thre_rise),
        .lsr_thre   (lsr_thre),
        .dma_tx_req (dma_tx_req)
    );

    uart_irq_prio u_prio (
        .pend (pend),
        .en   (en_vec),
        .irq  (irq),
        .code (code_e)
    );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for uart_irq_ctrl, attached with bind below.
// Assumes: connected to the top's ports and internal pending/enable vectors.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic [3:0]      iir_code,
    input logic            lsr_thre,
    input logic            dma_tx_req,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] en_vec,
    input logic            prog_on,
    input logic            thre_rise,
    input logic            ovr_err,
    input logic            par_err,
    input logic            frm_err,
    input logic            brk_det,
    input logic            rx_timeout,
    input logic            dcts,
    input logic            ddsr,
    input logic            teri,
    input logic            ddcd,
    input logic            auto_flow,
    input logic            lsr_rd,
    input logic            rbr_rd,
    input logic            iir_rd
);
    logic line_any;
    assign line_any = ovr_err | par_err | frm_err | brk_det;

    p_ls_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_any |=> pend[S_LS]);

    p_ls_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !line_any) |=> !pend[S_LS]);

    p_ls_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[S_LS] && en_vec[S_LS]) |-> (iir_code == ID_LS));

    p_rda_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[S_RDA] && en_vec[S_RDA] && !(pend[S_LS] && en_vec[S_LS]))
        |-> (iir_code == ID_RDA));

    p_to_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !rx_timeout) |=> !pend[S_TO]);

    p_thre_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_code == ID_THRE && !thre_rise) |=> !pend[S_THRE]);

    p_prog_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_on && !dma_tx_req) |=> !pend[S_THRE]);

    p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_on && lsr_thre) |-> !dma_tx_req);

    p_dma_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_on |-> (dma_tx_req == lsr_thre));

    p_cts_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dcts && auto_flow && !ddsr && !teri && !ddcd && !pend[S_MS])
        |=> !pend[S_MS]);

    p_irq_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_code != ID_NONE));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .iir_code   (iir_code),
    .lsr_thre   (lsr_thre),
    .dma_tx_req (dma_tx_req),
    .pend       (pend),
    .en_vec     (en_vec),
    .prog_on    (prog_on),
    .thre_rise  (thre_rise),
    .ovr_err    (ovr_err),
    .par_err    (par_err),
    .frm_err    (frm_err),
    .brk_det    (brk_det),
    .rx_timeout (rx_timeout),
    .dcts       (dcts),
    .ddsr       (ddsr),
    .teri       (teri),
    .ddcd       (ddcd),
    .auto_flow  (auto_flow),
    .lsr_rd     (lsr_rd),
    .rbr_rd     (rbr_rd),
    .iir_rd     (iir_rd)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
    localparam int TXD = 16;
    localparam int RLW = 5;
    localparam int TLW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 0, auto_flow = 0, cfg_wr = 0;
    logic [4:0] cfg_ier = '0;
    logic [1:0] cfg_tet = '0;
    logic ovr_err = 0, par_err = 0, frm_err = 0, brk_det = 0;
    logic [RLW-1:0] rx_level = '0;
    logic rx_trig = 0, rx_timeout = 0;
    logic [TLW-1:0] tx_level = '0;
    logic dcts = 0, ddsr = 0, teri = 0, ddcd = 0;
    logic lsr_rd = 0, rbr_rd = 0, iir_rd = 0, msr_rd = 0, thr_wr = 0;
    logic irq;
    logic [3:0] iir_code;
    logic lsr_thre, dma_tx_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .auto_flow(auto_flow),
        .cfg_wr(cfg_wr), .cfg_ier(cfg_ier), .cfg_tet(cfg_tet),
        .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
        .tx_level(tx_level), .dcts(dcts), .ddsr(ddsr), .teri(teri), .ddcd(ddcd),
        .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .iir_rd(iir_rd), .msr_rd(msr_rd),
        .thr_wr(thr_wr), .irq(irq), .iir_code(iir_code), .lsr_thre(lsr_thre),
        .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_ls, m_rda, m_to, m_thre, m_ms, m_cq;
    bit [4:0] m_ier;
    bit [1:0] m_tet;

    function automatic int m_thr();
        case (m_tet)
            2'd0: return 0;
            2'd1: return 2;
            2'd2: return TXD / 4;
            default: return TXD / 2;
        endcase
    endfunction

    function automatic bit m_prog();
        return m_ier[4] && fifo_en;
    endfunction

    function automatic bit m_cond();
        if (m_prog()) return int'(tx_level) <= m_thr();
        return tx_level == 0;
    endfunction

    function automatic int m_id();
        if (m_ls && m_ier[2]) return 6;
        if (m_rda && m_ier[0]) return 4;
        if (m_to && m_ier[0]) return 12;
        if (m_thre && m_ier[1]) return 2;
        if (m_ms && m_ier[3]) return 0;
        return 1;
    endfunction

    function automatic int m_lsr();
        if (m_prog()) return int'(tx_level == TXD);
        return int'(tx_level == 0);
    endfunction

    always @(posedge clk) begin
        bit c, p, rise, clr;
        if (!rst_n) begin
            m_ls <= 0; m_rda <= 0; m_to <= 0; m_thre <= 0; m_ms <= 0; m_cq <= 0;
            m_ier <= 0; m_tet <= 0;
        end else begin
            p = m_prog();
            c = m_cond();
            rise = c && !m_cq;
            clr = (p && !c) || (thr_wr && !p) || (iir_rd && m_id() == 2);
            m_thre <= rise || (m_thre && !clr);
            m_cq <= c;
            m_ls <= ovr_err || par_err || frm_err || brk_det || (m_ls && !lsr_rd);
            m_rda <= fifo_en ? rx_trig : (rx_level != 0);
            m_to <= rx_timeout || (m_to && !rbr_rd);
            m_ms <= (dcts && !auto_flow) || ddsr || teri || ddcd || (m_ms && !msr_rd);
            if (cfg_wr) begin
                m_ier <= cfg_ier;
                m_tet <= cfg_tet;
            end
        end
    end

    // Per-cycle comparison, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R11 irq", irq, int'(m_id() != 1));
            chk("R11 iir_code", iir_code, m_id());
            chk("R8 lsr_thre", lsr_thre, m_lsr());
            chk("R9 dma_tx_req", dma_tx_req, int'(m_cond()));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 50000 && !done) begin
            done = 1;
            n_fail++;
            n_chk++;
            $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", cyc_cnt, 50000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clr_pulses();
        cfg_wr = 0; ovr_err = 0; par_err = 0; frm_err = 0; brk_det = 0;
        rx_timeout = 0; dcts = 0; ddsr = 0; teri = 0; ddcd = 0;
        lsr_rd = 0; rbr_rd = 0; iir_rd = 0; msr_rd = 0; thr_wr = 0;
    endtask

    task automatic cfg(input logic [4:0] ier, input logic [1:0] tet);
        cfg_wr = 1; cfg_ier = ier; cfg_tet = tet;
        step(); clr_pulses();
    endtask

    initial begin
        repeat (4) step();
        // R1: state while in reset
        chk("R1 irq in reset", irq, 0);
        chk("R1 iir_code in reset", iir_code, 1);
        rst_n = 1;
        step();
        chk("R1 irq after reset", irq, 0);
        chk("R1 iir_code after reset", iir_code, 1);

        // R6: transmit cause latched at the empty edge after reset
        cfg(5'b01111, 2'b00);
        chk("R6 thre shown", iir_code, 2);
        chk("R11 irq with thre", irq, 1);
        iir_rd = 1; step(); clr_pulses();
        chk("R6 identity read clears", iir_code, 1);
        step();
        chk("R6 no re-raise while empty", iir_code, 1);

        // R2 with R4 beneath it
        ovr_err = 1; rx_timeout = 1; step(); clr_pulses();
        chk("R2 overrun shown over timeout", iir_code, 6);
        lsr_rd = 1; step(); clr_pulses();
        chk("R4 timeout after lsr read", iir_code, 12);
        rbr_rd = 1; step(); clr_pulses();
        chk("R4 rbr read clears timeout", iir_code, 1);
        for (int k = 0; k < 3; k++) begin
            par_err = (k == 0); frm_err = (k == 1); brk_det = (k == 2);
            step(); clr_pulses();
            chk("R2 line error shown", iir_code, 6);
            lsr_rd = 1; step(); clr_pulses();
            chk("R2 lsr read clears", iir_code, 1);
        end

        // R3: non-FIFO data present
        rx_level = 1; rx_timeout = 1; step(); clr_pulses();
        chk("R3 data ranks above timeout", iir_code, 4);
        rx_level = 0; step();
        chk("R4 timeout remains", iir_code, 12);
        rbr_rd = 1; step(); clr_pulses();
        chk("R4 cleared", iir_code, 1);
        // R3: FIFO mode uses trigger state only
        fifo_en = 1; rx_level = 3; step();
        chk("R3 level ignored in FIFO mode", iir_code, 1);
        rx_trig = 1; step();
        chk("R3 trigger raises data", iir_code, 4);
        rx_trig = 0; rx_level = 0; step();
        chk("R3 trigger drop clears", iir_code, 1);

        // R5: shared enable bit
        cfg(5'b01110, 2'b00);
        rx_trig = 1; rx_timeout = 1; step(); clr_pulses();
        chk("R5 irq masked", irq, 0);
        chk("R5 iir_code masked", iir_code, 1);
        cfg(5'b01111, 2'b00);
        chk("R5 data after enable", iir_code, 4);
        rx_trig = 0; step();
        chk("R5 timeout under same bit", iir_code, 12);
        rbr_rd = 1; step(); clr_pulses();
        chk("R5 cleared", iir_code, 1);

        // R10: modem causes
        auto_flow = 1; dcts = 1; step(); clr_pulses();
        chk("R10 cts masked by flow control", iir_code, 1);
        auto_flow = 0; dcts = 1; step(); clr_pulses();
        chk("R10 cts change shown", iir_code, 0);
        chk("R10 irq", irq, 1);
        msr_rd = 1; step(); clr_pulses();
        chk("R10 msr read clears", iir_code, 1);
        for (int k = 0; k < 3; k++) begin
            ddsr = (k == 0); teri = (k == 1); ddcd = (k == 2);
            step(); clr_pulses();
            chk("R10 modem change shown", iir_code, 0);
            msr_rd = 1; step(); clr_pulses();
            chk("R10 cleared", iir_code, 1);
        end

        // R6: normal mode, holding-register write clears
        tx_level = 3; step();
        chk("R6 not empty", iir_code, 1);
        tx_level = 0; step();
        chk("R6 empty edge raises", iir_code, 2);
        thr_wr = 1; step(); clr_pulses();
        chk("R6 thr write clears", iir_code, 1);

        // R7/R8/R9: programmable mode, quarter threshold = 4
        tx_level = 10;
        cfg(5'b11111, 2'b10);
        chk("R7 above threshold", iir_code, 1);
        chk("R8 not full", lsr_thre, 0);
        chk("R9 no request above", dma_tx_req, 0);
        tx_level = 16; step();
        chk("R8 full reported", lsr_thre, 1);
        chk("R9 no request when full", dma_tx_req, 0);
        tx_level = 4; step();
        chk("R7 quarter reached", iir_code, 2);
        chk("R9 request at threshold", dma_tx_req, 1);
        chk("R8 not full at threshold", lsr_thre, 0);
        tx_level = 5; step();
        chk("R7 above quarter clears", iir_code, 1);
        // two-entry threshold
        cfg(5'b11111, 2'b01);
        tx_level = 3; step();
        chk("R7 three above two", iir_code, 1);
        tx_level = 2; step();
        chk("R7 two reached", iir_code, 2);
        tx_level = 9; step();
        chk("R7 cleared", iir_code, 1);
        // half threshold = 8
        cfg(5'b11111, 2'b11);
        tx_level = 8; step();
        chk("R7 half reached", iir_code, 2);
        tx_level = 9; step();
        chk("R7 above half clears", iir_code, 1);
        // empty threshold
        cfg(5'b11111, 2'b00);
        tx_level = 1; step();
        chk("R7 one above empty", iir_code, 1);
        tx_level = 0; step();
        chk("R7 empty reached", iir_code, 2);
        iir_rd = 1; step(); clr_pulses();
        chk("R7 identity read clears", iir_code, 1);
        step();
        chk("R7 stays clear at same level", iir_code, 1);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ovr_err = ($urandom % 24) == 0;
            par_err = ($urandom % 24) == 0;
            frm_err = ($urandom % 24) == 0;
            brk_det = ($urandom % 24) == 0;
            rx_timeout = ($urandom % 16) == 0;
            dcts = ($urandom % 12) == 0;
            ddsr = ($urandom % 24) == 0;
            teri = ($urandom % 24) == 0;
            ddcd = ($urandom % 24) == 0;
            lsr_rd = ($urandom % 6) == 0;
            rbr_rd = ($urandom % 6) == 0;
            iir_rd = ($urandom % 5) == 0;
            msr_rd = ($urandom % 6) == 0;
            thr_wr = ($urandom % 6) == 0;
            if (($urandom % 4) == 0) tx_level = TLW'($urandom % 17);
            if (($urandom % 4) == 0) rx_level = RLW'($urandom % 17);
            if (($urandom % 5) == 0) rx_trig = ~rx_trig;
            cfg_wr = ($urandom % 48) == 0;
            cfg_ier = 5'($urandom);
            cfg_tet = 2'($urandom);
            if (($urandom % 100) == 0) fifo_en = ~fifo_en;
            if (($urandom % 100) == 0) auto_flow = ~auto_flow;
        end
        @(negedge clk);
        clr_pulses();
        repeat (3) step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule